// File: doc/BRIEF.md
# Grouped-Priority Nested Interrupt Arbiter

This block arbitrates a parameterised set of interrupt request lines for a single core. Each line carries an enable bit, a pending bit, an active bit and an 8-bit priority byte of which only the upper `PRIO_BITS` bits exist. Software reaches all of this state through a simple word-addressed register bus. That bus offers write-one-to-set and write-one-to-clear views of enables and pendings, a software trigger that pends a line by number, and packed priority words that take byte-lane writes. A lower priority value is more urgent.

The arbiter picks the most urgent eligible pending line. A line is eligible when it is enabled and pending, the global disable is off, and it passes the threshold mask. The arbiter raises a request to the core only if that line's preemption level beats the running level of the lines already in service. A 3-bit group field sets where each priority byte divides into a preemption part and a sub-priority part. An acknowledge moves the winner from pending to active, and an end-of-interrupt strobe retires an active line. A non-maskable input is passed straight through to its own output, and no mask touches it.

Word map (word addresses): 0 enable-set, 1 enable-clear, 2 pending-set, 3 pending-clear, 4 active (read only), 5 control, 6 software trigger, 8 and up priority words.

Top module: `irq_prio_arbiter`

## Requirements
- R1: After reset, every enable, pending and active bit is 0, every priority byte is 0, the control word (group in bits [2:0], global disable in bit 3, threshold in bits [15:8]) reads 0, and `irq_req` is 0.
- R2: Priority word 8+k holds line 4k+b in bits [8b+7:8b]. Each byte lane is written only when its `bus_be` bit is 1. The low 8-`PRIO_BITS` bits of every priority byte, and of the threshold, always read 0.
- R3: A write to word 0 or word 2 sets the enable or pending bits where the data bit is 1. A write to word 1 or word 3 clears them where the data bit is 1. Data bits of 0 change nothing. Words 0–1 read back the enables and words 2–3 read back the pendings.
- R4: A write to word 6 with a line number below `NUM_LINES` in bits [7:0] sets that line's pending bit. A number at or above `NUM_LINES` changes no state.
- R5: Among eligible lines, the winner on `irq_id` is the one with the lowest full priority byte. On a tie, the lowest line number wins.
- R6: For group g below 7, the preemption level is the priority byte with bits [g:0] forced to 0. For g = 7, every line has preemption level 0, so nothing preempts an active line.
- R7: With a non-zero threshold, a line whose priority is numerically at or above the threshold is not eligible. A threshold of 0 masks nothing.
- R8: While the global disable bit is 1, `irq_req` is 0. `nmi_req` equals `nmi_in` whatever the masks are.
- R9: `irq_ack` while `irq_req` is 1 clears the winner's pending bit and sets its active bit (word 4). `eoi_valid` clears the active bit of line `eoi_id`.
- R10: `irq_req` is 1 only if an eligible line exists and its preemption level is numerically below the running level. The running level is the lowest preemption level among active lines, or above every level when no line is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Word address for reads and writes |
| bus_be | input | 4 | Byte-lane enables, used by priority and control words |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_ack | input | 1 | Core takes the presented request |
| eoi_valid | input | 1 | End of service for line `eoi_id` |
| eoi_id | input | ID_W | Line being retired |
| nmi_in | input | 1 | Non-maskable request input |
| irq_req | output | 1 | Maskable request to the core |
| irq_id | output | ID_W | Line number of the presented request |
| nmi_req | output | 1 | Non-maskable request to the core |

## Verification
Every state change, whether from a bus write, an acknowledge or an end-of-interrupt, lands on the clock edge that samples the strobe. `irq_req`, `irq_id` and `bus_rdata` are combinational from that registered state, so each result is due one edge after its stimulus. The bench drives inputs 2 ns after a rising edge. It reads the register bus 1 ns later, with nothing in between, and it compares the request outputs against a behavioural model at every falling edge. `nmi_req` has no register on its path and is checked in the same half cycle as `nmi_in`.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

    typedef logic [7:0] prio_t;

    localparam int unsigned ADR_EN_SET   = 0;
    localparam int unsigned ADR_EN_CLR   = 1;
    localparam int unsigned ADR_PND_SET  = 2;
    localparam int unsigned ADR_PND_CLR  = 3;
    localparam int unsigned ADR_ACTIVE   = 4;
    localparam int unsigned ADR_CTRL     = 5;
    localparam int unsigned ADR_SWTRIG   = 6;
    localparam int unsigned ADR_PRIO0    = 8;

    // Bits of a priority byte that form the preemption level for group g.
    function automatic prio_t preempt_mask(input logic [2:0] g);
        prio_t m;
        if (g == 3'd7) m = 8'h00;
        else           m = prio_t'(9'h0FF << (int'(g) + 1));
        return m;
    endfunction

    function automatic prio_t impl_mask(input int unsigned nbits);
        return prio_t'(9'h0FF << (8 - nbits));
    endfunction

endpackage

// File: rtl/irq_arb_regs.sv
module irq_arb_regs
    import irq_arb_pkg::*;
#(
    parameter int unsigned NUM_LINES = 8,
    parameter int unsigned PRIO_BITS = 3,
    parameter int unsigned ADDR_W    = 5,
    parameter int unsigned ID_W      = $clog2(NUM_LINES)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          bus_we,
    input  logic [ADDR_W-1:0]             bus_addr,
    input  logic [3:0]                    bus_be,
    input  logic [31:0]                   bus_wdata,
    output logic [31:0]                   bus_rdata,
    input  logic                          ack_fire,
    input  logic [ID_W-1:0]               ack_id,
    input  logic                          eoi_valid,
    input  logic [ID_W-1:0]               eoi_id,
    output logic [NUM_LINES-1:0]          en_o,
    output logic [NUM_LINES-1:0]          pend_o,
    output logic [NUM_LINES-1:0]          act_o,
    output logic [NUM_LINES-1:0][7:0]     prio_o,
    output logic [2:0]                    grp_o,
    output logic                          gdis_o,
    output logic [7:0]                    thr_o
);

    localparam prio_t IMPL = impl_mask(PRIO_BITS);

    typedef struct packed {
        logic [NUM_LINES-1:0]      en;
        logic [NUM_LINES-1:0]      pend;
        logic [NUM_LINES-1:0]      act;
        logic [NUM_LINES-1:0][7:0] prio;
        logic [2:0]                grp;
        logic                      gdis;
        logic [7:0]                thr;
    } st_t;

    st_t st_d, st_q;
    int unsigned adr;

    assign adr = int'(bus_addr);

    always_comb begin
        st_d = st_q;
        if (bus_we) begin
            if (adr == ADR_EN_SET)  st_d.en   = st_q.en   |  bus_wdata[NUM_LINES-1:0];
            if (adr == ADR_EN_CLR)  st_d.en   = st_q.en   & ~bus_wdata[NUM_LINES-1:0];
            if (adr == ADR_PND_SET) st_d.pend = st_q.pend |  bus_wdata[NUM_LINES-1:0];
            if (adr == ADR_PND_CLR) st_d.pend = st_q.pend & ~bus_wdata[NUM_LINES-1:0];
            if (adr == ADR_SWTRIG && int'(bus_wdata[7:0]) < NUM_LINES)
                st_d.pend[bus_wdata[ID_W-1:0]] = 1'b1;
            if (adr == ADR_CTRL) begin
                if (bus_be[0]) begin
                    st_d.grp  = bus_wdata[2:0];
                    st_d.gdis = bus_wdata[3];
                end
                if (bus_be[1]) st_d.thr = bus_wdata[15:8] & IMPL;
            end
            for (int i = 0; i < NUM_LINES; i++) begin
                if (adr == ADR_PRIO0 + i / 4 && bus_be[i % 4])
                    st_d.prio[i] = bus_wdata[8*(i%4) +: 8] & IMPL;
            end
        end
        if (ack_fire) begin
            st_d.pend[ack_id] = 1'b0;
            st_d.act[ack_id]  = 1'b1;
        end
        if (eoi_valid) st_d.act[eoi_id] = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        bus_rdata = '0;
        case (adr)
            ADR_EN_SET, ADR_EN_CLR:   bus_rdata[NUM_LINES-1:0] = st_q.en;
            ADR_PND_SET, ADR_PND_CLR: bus_rdata[NUM_LINES-1:0] = st_q.pend;
            ADR_ACTIVE:               bus_rdata[NUM_LINES-1:0] = st_q.act;
            ADR_CTRL:                 bus_rdata[15:0] = {st_q.thr, 4'b0, st_q.gdis, st_q.grp};
            default: begin
                for (int i = 0; i < NUM_LINES; i++) begin
                    if (adr == ADR_PRIO0 + i / 4) bus_rdata[8*(i%4) +: 8] = st_q.prio[i];
                end
            end
        endcase
    end

    assign en_o   = st_q.en;
    assign pend_o = st_q.pend;
    assign act_o  = st_q.act;
    assign prio_o = st_q.prio;
    assign grp_o  = st_q.grp;
    assign gdis_o = st_q.gdis;
    assign thr_o  = st_q.thr;

    // R9: acknowledge moves the line from pending to active
    p_ack_moves_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_fire && !bus_we && !(eoi_valid && eoi_id == ack_id))
        |=> (st_q.act[$past(ack_id)] && !st_q.pend[$past(ack_id)]));

    // R9: end-of-interrupt retires the line
    p_eoi_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_valid |=> !st_q.act[$past(eoi_id)]);

    // R4: software trigger pends an in-range line
    p_trig_pends_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && adr == ADR_SWTRIG && int'(bus_wdata[7:0]) < NUM_LINES && !ack_fire)
        |=> st_q.pend[$past(bus_wdata[ID_W-1:0])]);

endmodule

// File: rtl/irq_arb_select.sv
module irq_arb_select #(
    parameter int unsigned NUM_LINES = 8,
    parameter int unsigned ID_W      = $clog2(NUM_LINES)
) (
    input  logic [NUM_LINES-1:0]      en,
    input  logic [NUM_LINES-1:0]      pend,
    input  logic [NUM_LINES-1:0][7:0] prio,
    input  logic                      gdis,
    input  logic [7:0]                thr,
    output logic                      win_valid,
    output logic [ID_W-1:0]           win_id,
    output logic [7:0]                win_prio
);

    logic [NUM_LINES-1:0] elig;

    always_comb begin
        for (int i = 0; i < NUM_LINES; i++) begin
            elig[i] = en[i] && pend[i] && !gdis && (thr == 8'h00 || prio[i] < thr);
        end
    end

    // Ascending scan with strict compare keeps the lowest index on ties.
    always_comb begin
        win_valid = 1'b0;
        win_id    = '0;
        win_prio  = 8'hFF;
        for (int i = 0; i < NUM_LINES; i++) begin
            if (elig[i] && (!win_valid || prio[i] < win_prio)) begin
                win_valid = 1'b1;
                win_id    = ID_W'(i);
                win_prio  = prio[i];
            end
        end
    end

endmodule

// File: rtl/irq_arb_level.sv
module irq_arb_level
    import irq_arb_pkg::*;
#(
    parameter int unsigned NUM_LINES = 8
) (
    input  logic [NUM_LINES-1:0]      act,
    input  logic [NUM_LINES-1:0][7:0] prio,
    input  logic [2:0]                grp,
    output logic [8:0]                run_level
);

    prio_t pm;
    assign pm = preempt_mask(grp);

    // 9'h100 stands for "idle": above every real level.
    always_comb begin
        run_level = 9'h100;
        for (int i = 0; i < NUM_LINES; i++) begin
            if (act[i] && {1'b0, prio[i] & pm} < run_level)
                run_level = {1'b0, prio[i] & pm};
        end
    end

endmodule

// File: rtl/irq_prio_arbiter.sv
module irq_prio_arbiter
    import irq_arb_pkg::*;
#(
    parameter int unsigned NUM_LINES = 8,
    parameter int unsigned PRIO_BITS = 3,
    parameter int unsigned ADDR_W    = 5,
    parameter int unsigned ID_W      = $clog2(NUM_LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [3:0]        bus_be,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              irq_ack,
    input  logic              eoi_valid,
    input  logic [ID_W-1:0]   eoi_id,
    input  logic              nmi_in,
    output logic              irq_req,
    output logic [ID_W-1:0]   irq_id,
    output logic              nmi_req
);

    logic [NUM_LINES-1:0]      en, pend, act;
    logic [NUM_LINES-1:0][7:0] prio;
    logic [2:0]                grp;
    logic                      gdis;
    logic [7:0]                thr;
    logic                      win_valid;
    logic [ID_W-1:0]           win_id;
    logic [7:0]                win_prio;
    logic [8:0]                run_level;
    logic                      ack_fire;

    assign ack_fire = irq_ack && irq_req;

    irq_arb_regs #(
        .NUM_LINES(NUM_LINES), .PRIO_BITS(PRIO_BITS), .ADDR_W(ADDR_W), .ID_W(ID_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_be(bus_be),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ack_fire(ack_fire), .ack_id(win_id),
        .eoi_valid(eoi_valid), .eoi_id(eoi_id),
        .en_o(en), .pend_o(pend), .act_o(act), .prio_o(prio),
        .grp_o(grp), .gdis_o(gdis), .thr_o(thr)
    );

    irq_arb_select #(.NUM_LINES(NUM_LINES), .ID_W(ID_W)) u_sel (
        .en(en), .pend(pend), .prio(prio), .gdis(gdis), .thr(thr),
        .win_valid(win_valid), .win_id(win_id), .win_prio(win_prio)
    );

    irq_arb_level #(.NUM_LINES(NUM_LINES)) u_lvl (
        .act(act), .prio(prio), .grp(grp), .run_level(run_level)
    );

    assign irq_req = win_valid && ({1'b0, win_prio & preempt_mask(grp)} < run_level);
    assign irq_id  = win_id;
    assign nmi_req = nmi_in;

    // R8: global disable silences the maskable request
    p_gdis_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        gdis |-> !irq_req);

    // R7: a presented line always sits below a non-zero threshold
    p_thresh_masks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && thr != 8'h00) |-> (prio[irq_id] < thr));

    // R10: a request must strictly beat the running level
    p_strict_preempt_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> ({1'b0, prio[irq_id] & preempt_mask(grp)} < run_level));

    // R5: the presented line is enabled and pending
    p_winner_live_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (en[irq_id] && pend[irq_id]));

endmodule

// File: tb/tb_irq_prio_arbiter.sv
module tb_irq_prio_arbiter;

    localparam int N = 8;
    localparam int IW = 3;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        bus_we = 0;
    logic [4:0]  bus_addr = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_ack = 0;
    logic        eoi_valid = 0;
    logic [IW-1:0] eoi_id = '0;
    logic        nmi_in = 0;
    logic        irq_req, nmi_req;
    logic [IW-1:0] irq_id;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    irq_prio_arbiter dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_ack(irq_ack), .eoi_valid(eoi_valid), .eoi_id(eoi_id),
        .nmi_in(nmi_in), .irq_req(irq_req), .irq_id(irq_id), .nmi_req(nmi_req)
    );

    // ---------------- behavioural reference model ----------------
    bit m_en[N], m_pend[N], m_act[N];
    int m_prio[N];
    int m_grp, m_thr;
    bit m_gdis;

    function automatic int pmask(int g);
        if (g == 7) return 0;
        return (255 << (g + 1)) & 255;
    endfunction

    function automatic void model_out(output bit req, output int id);
        int best = -1;
        int run = 256;
        for (int i = 0; i < N; i++) begin
            if (m_act[i] && (m_prio[i] & pmask(m_grp)) < run) run = m_prio[i] & pmask(m_grp);
            if (m_en[i] && m_pend[i] && !m_gdis && (m_thr == 0 || m_prio[i] < m_thr))
                if (best < 0 || m_prio[i] < m_prio[best]) best = i;
        end
        id  = (best < 0) ? 0 : best;
        req = (best >= 0) && ((m_prio[id] & pmask(m_grp)) < run);
    endfunction

    always @(posedge clk) begin
        bit r;
        int id;
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                m_en[i] = 0; m_pend[i] = 0; m_act[i] = 0; m_prio[i] = 0;
            end
            m_grp = 0; m_thr = 0; m_gdis = 0;
        end else begin
            model_out(r, id);
            if (bus_we) begin
                for (int i = 0; i < N; i++) begin
                    if (bus_addr == 0 && bus_wdata[i]) m_en[i] = 1;
                    if (bus_addr == 1 && bus_wdata[i]) m_en[i] = 0;
                    if (bus_addr == 2 && bus_wdata[i]) m_pend[i] = 1;
                    if (bus_addr == 3 && bus_wdata[i]) m_pend[i] = 0;
                    if (int'(bus_addr) == 8 + i / 4 && bus_be[i % 4])
                        m_prio[i] = int'((bus_wdata >> (8 * (i % 4))) & 32'hE0);
                end
                if (bus_addr == 6 && int'(bus_wdata[7:0]) < N) m_pend[bus_wdata[7:0]] = 1;
                if (bus_addr == 5) begin
                    if (bus_be[0]) begin m_grp = int'(bus_wdata[2:0]); m_gdis = bus_wdata[3]; end
                    if (bus_be[1]) m_thr = int'(bus_wdata[15:8]) & 'hE0;
                end
            end
            if (irq_ack && r) begin m_pend[id] = 0; m_act[id] = 1; end
            if (eoi_valid) m_act[eoi_id] = 0;
        end
    end

    // every-cycle comparison of the request outputs (R5, R10)
    always @(negedge clk) begin
        bit r;
        int id;
        if (rst_n && !done) begin
            model_out(r, id);
            checks++;
            if (irq_req !== r || (r && int'(irq_id) != id)) begin
                fails++;
                $display("FAIL R10/R5 cycle compare: req=%0b id=%0d expected req=%0b id=%0d",
                         irq_req, irq_id, r, id);
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(input int a, input logic [31:0] d, input logic [3:0] be = 4'hF);
        @(posedge clk); #2;
        bus_we = 1; bus_addr = 5'(a); bus_wdata = d; bus_be = be;
        @(posedge clk); #2;
        bus_we = 0; bus_be = '0; bus_wdata = '0;
    endtask

    task automatic rd(input int a, input logic [31:0] exp, input string tag);
        bus_addr = 5'(a); #1;
        checks++;
        if (bus_rdata !== exp) begin
            fails++;
            $display("FAIL %s read word %0d: got %h expected %h", tag, a, bus_rdata, exp);
        end
    endtask

    task automatic chk_req(input bit exp_req, input int exp_id, input string tag);
        checks++;
        if (irq_req !== exp_req || (exp_req && int'(irq_id) != exp_id)) begin
            fails++;
            $display("FAIL %s: req=%0b id=%0d expected req=%0b id=%0d",
                     tag, irq_req, irq_id, exp_req, exp_id);
        end
    endtask

    task automatic ack();
        @(posedge clk); #2; irq_ack = 1;
        @(posedge clk); #2; irq_ack = 0;
    endtask

    task automatic eoi(input int l);
        @(posedge clk); #2; eoi_valid = 1; eoi_id = IW'(l);
        @(posedge clk); #2; eoi_valid = 0;
    endtask

    task automatic ctrl(input int g, input bit dis, input int thr);
        wr(5, {16'h0, 8'(thr), 4'h0, dis, 3'(g)}, 4'b0011);
    endtask

    // ---------------- directed sequence ----------------
    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1;
        // R1 reset state
        rd(0, 32'h0, "R1 enables");
        rd(2, 32'h0, "R1 pendings");
        rd(4, 32'h0, "R1 actives");
        rd(5, 32'h0, "R1 control");
        rd(8, 32'h0, "R1 priority word");
        chk_req(0, 0, "R1 request idle");

        // R2 priority lanes and unimplemented bits
        wr(8, 32'h6040FF20);
        rd(8, 32'h6040E020, "R2 full word");
        wr(8, 32'h00A00000, 4'b0100);
        rd(8, 32'h60A0E020, "R2 byte lane");

        // R3 set/clear semantics
        wr(0, 32'h0F);
        rd(0, 32'h0F, "R3 enable set");
        wr(1, 32'h02);
        rd(1, 32'h0D, "R3 enable clear");
        wr(1, 32'h00);
        rd(0, 32'h0D, "R3 zero write ignored");
        wr(2, 32'h04);
        rd(2, 32'h04, "R3 pending set");
        chk_req(1, 2, "R5 single pending");

        // R4 software trigger
        wr(6, 32'd3);
        rd(3, 32'h0C, "R4 trigger in range");
        wr(6, 32'd9);
        rd(2, 32'h0C, "R4 trigger out of range");
        chk_req(1, 3, "R5 lower value wins");

        // R5 tie on value: lowest line wins
        wr(9, 32'h60, 4'b0001);
        rd(9, 32'h60, "R2 second word");
        wr(0, 32'h10);
        wr(2, 32'h10);
        chk_req(1, 3, "R5 tie lowest line");

        // R7 threshold
        ctrl(0, 0, 8'h60);
        chk_req(0, 0, "R7 threshold blocks");
        ctrl(0, 0, 8'h80);
        chk_req(1, 3, "R7 threshold passes");
        ctrl(0, 0, 0);
        chk_req(1, 3, "R7 zero threshold");

        // R8 global disable and NMI bypass
        ctrl(0, 1, 0);
        nmi_in = 1; #1;
        chk_req(0, 0, "R8 global disable");
        checks++;
        if (nmi_req !== 1'b1) begin
            fails++; $display("FAIL R8 nmi bypass: got %0b expected 1", nmi_req);
        end
        nmi_in = 0;
        ctrl(0, 0, 0);

        // R9 acknowledge / R10 strict preemption
        ack();
        rd(4, 32'h08, "R9 active after ack");
        rd(2, 32'h14, "R9 pending after ack");
        chk_req(0, 0, "R10 equal level no preempt");
        wr(6, 32'd0);
        chk_req(1, 0, "R10 more urgent preempts");
        ack();
        rd(4, 32'h09, "R9 nested active");
        eoi(0);
        rd(4, 32'h08, "R9 eoi clears");
        chk_req(0, 0, "R10 after eoi");

        // R6 group split
        wr(6, 32'd0);
        chk_req(1, 0, "R10 pending again");
        ctrl(6, 0, 0);
        chk_req(0, 0, "R6 group 6 merges levels");
        ctrl(4, 0, 0);
        chk_req(1, 0, "R6 group 4 splits levels");
        ctrl(7, 0, 0);
        chk_req(0, 0, "R6 group 7 no preemption");
        ctrl(0, 0, 0);
        eoi(3);
        rd(4, 32'h00, "R9 all retired");
        chk_req(1, 0, "R10 idle accepts");

        repeat (4) @(posedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule